// File: doc/BRIEF.md
# Serial Receiver with Address-Bit Filtering

This block receives asynchronous serial frames on one line. A falling edge on the line starts a frame. The start bit is then checked half a bit period later, and the data bits are sampled at the centre of each bit, least significant bit first. A frame carries eight or nine data bits. The received word goes into a one-entry holding register. The stop-bit level (8-bit mode) or the ninth data bit (9-bit mode) is kept in a separate status bit.

An optional filter supports multi-drop links where one station talks to several. When the filter is on, a frame whose flag bit is 0 is thrown away without any trace. The flag bit is the stop bit in 8-bit mode and the ninth data bit in 9-bit mode. Only frames whose flag bit is 1 reach the holding register, so a node can wait for address frames and ignore data meant for other nodes.

Three conditions are reported, each of which can raise the interrupt output through its own enable bit: a failed start check, an overrun, and a full holding register.

Top module: `uart_mp_rx`

## Requirements
- R1: The line passes through a two-flop synchroniser. A falling edge starts a frame, and the start bit is confirmed bit_period_i/2 cycles later. Data bits are then sampled every bit_period_i cycles, least significant bit first. bit_period_i is in clock cycles and must be at least 4.
- R2: If the line is high at the start check, the frame is abandoned, start_err_o is set and the receiver waits for the next falling edge. A flagged start error does not stop later frames from being received.
- R3: In 8-bit mode (nine_bit_i=0) with the filter off, the byte goes to rx_data_o and the stop-bit level goes to rx_bit8_o, both when the stop bit is sampled. A stop bit of 0 is still stored.
- R4: With the filter on (mp_filter_i=1), a frame whose flag bit is 0 is dropped. rx_data_o, rx_bit8_o and all three flags then keep their values.
- R5: In 9-bit mode, nine data bits are received. Bits 7..0 go to rx_data_o and the ninth bit goes to rx_bit8_o. The stop-bit level is ignored, and with the filter on the ninth bit decides whether the frame is stored.
- R6: Storing a frame sets rx_full_o. A one-cycle rd_data_i pulse clears it. Deasserting en_i does not clear it.
- R7: A stored-eligible frame that completes while rx_full_o is 1 leaves rx_data_o unchanged and sets rx_ovf_o. rx_bit8_o is still overwritten with the new frame's flag bit.
- R8: A one-cycle rd_stat_i pulse clears start_err_o and rx_ovf_o. While en_i is 0, both flags are held at 0 and the receiver stays idle.
- R9: irq_o is the OR of each flag ANDed with its enable: irq_en_i[0] for start_err_o, irq_en_i[1] for rx_ovf_o, irq_en_i[2] for rx_full_o.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| rxd_i | input | 1 | Serial line, idle high |
| bit_period_i | input | CNT_W | Bit length in clock cycles |
| nine_bit_i | input | 1 | 1: nine data bits, 0: eight |
| mp_filter_i | input | 1 | Drop frames whose flag bit is 0 |
| rd_data_i | input | 1 | Data register read strobe |
| rd_stat_i | input | 1 | Status register read strobe |
| irq_en_i | input | 3 | Interrupt enables {full, overflow, start error} |
| rx_data_o | output | 8 | Received data byte |
| rx_bit8_o | output | 1 | Captured stop bit or ninth bit |
| rx_full_o | output | 1 | Holding register full |
| rx_ovf_o | output | 1 | Overrun flag |
| start_err_o | output | 1 | Start-bit check failed |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions check the following on every cycle:
- The receiver stays idle without a falling edge.
- A failed start check always returns the receiver to idle.
- The full flag rises only on a completed frame and falls only on a data read.
- An overrun leaves the data register untouched.
- Disable clears the error flags.
- The interrupt is silent when all enables are off.

Only the bench scenarios can show the following:
- The assembled values, including bit order and nine-bit assembly.
- That filtered frames leave no trace.
- The flag-bit overwrite during overrun.
- Recovery after a start glitch.
- Which flags survive disable.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam int IRQ_SERR = 0;
  localparam int IRQ_OVF  = 1;
  localparam int IRQ_FULL = 2;
  localparam int IRQ_W    = 3;
  localparam int WORD_W   = 9;
endpackage

// File: rtl/uart_mp_rx_sync.sv
module uart_mp_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);
  // one extra flop holds the previous synchronised value for edge detection
  logic [STAGES:0] chain_q;

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= rxd_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign line_o = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/uart_mp_rx_frame.sv
module uart_mp_rx_frame
  import uart_mp_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] bit_period_i,
  input  logic             nine_bit_i,
  input  logic             mp_filter_i,
  output logic             done_o,
  output logic [7:0]       data_o,
  output logic             bit8_o,
  output logic             start_fail_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        idx_q;
  logic [WORD_W-1:0] sh_q;
  logic              tick;
  logic [3:0]        last_idx;

  assign tick     = (cnt_q == '0);
  assign last_idx = nine_bit_i ? 4'd8 : 4'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: if (fall_i) begin
          state_q <= RX_START;
          cnt_q   <= (bit_period_i >> 1) - CNT_W'(1);
        end
        RX_START: begin
          if (!tick) cnt_q <= cnt_q - CNT_W'(1);
          else if (!line_i) begin
            state_q <= RX_DATA;
            cnt_q   <= bit_period_i - CNT_W'(1);
            idx_q   <= '0;
          end else state_q <= RX_IDLE;
        end
        RX_DATA: begin
          if (!tick) cnt_q <= cnt_q - CNT_W'(1);
          else begin
            sh_q  <= {line_i, sh_q[WORD_W-1:1]};
            idx_q <= idx_q + 4'd1;
            cnt_q <= bit_period_i - CNT_W'(1);
            if (idx_q == last_idx) state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (!tick) cnt_q <= cnt_q - CNT_W'(1);
          else state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // 8-bit frames end up in the upper eight flops after shifting right
  assign data_o       = nine_bit_i ? sh_q[7:0] : sh_q[8:1];
  assign bit8_o       = nine_bit_i ? sh_q[8] : line_i;
  assign done_o       = en_i && (state_q == RX_STOP) && tick && (!mp_filter_i || bit8_o);
  assign start_fail_o = en_i && (state_q == RX_START) && tick && line_i;

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && !fall_i) |=> (state_q == RX_IDLE));

  // R2
  start_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fail_o |=> (state_q == RX_IDLE));
endmodule

// File: rtl/uart_mp_rx_status.sv
module uart_mp_rx_status
  import uart_mp_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             done_i,
  input  logic [7:0]       data_i,
  input  logic             bit8_i,
  input  logic             start_fail_i,
  input  logic             rd_data_i,
  input  logic             rd_stat_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  output logic [7:0]       data_o,
  output logic             bit8_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             serr_o,
  output logic             irq_o
);
  logic [7:0] data_q;
  logic       bit8_q, full_q, ovf_q, serr_q;
  logic       store;

  assign store = done_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      bit8_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (done_i) bit8_q <= bit8_i;  // no overrun protection on this bit
      if (store) data_q <= data_i;
      if (store) full_q <= 1'b1;
      else if (rd_data_i) full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      serr_q <= 1'b0;
    end else if (!en_i) begin
      ovf_q  <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (done_i && full_q) ovf_q <= 1'b1;
      else if (rd_stat_i) ovf_q <= 1'b0;
      if (start_fail_i) serr_q <= 1'b1;
      else if (rd_stat_i) serr_q <= 1'b0;
    end
  end

  logic [IRQ_W-1:0] flags;
  assign flags[IRQ_SERR] = serr_q;
  assign flags[IRQ_OVF]  = ovf_q;
  assign flags[IRQ_FULL] = full_q;

  assign irq_o  = |(flags & irq_en_i);
  assign data_o = data_q;
  assign bit8_o = bit8_q;
  assign full_o = full_q;
  assign ovf_o  = ovf_q;
  assign serr_o = serr_q;

  // R6
  full_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rd_data_i) |=> full_q);

  // R6
  full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(done_i));

  // R7
  ovf_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_q) |=> $stable(data_q));

  // R8
  dis_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ovf_q && !serr_q));
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_rx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rxd_i,
  input  logic [CNT_W-1:0] bit_period_i,
  input  logic             nine_bit_i,
  input  logic             mp_filter_i,
  input  logic             rd_data_i,
  input  logic             rd_stat_i,
  input  logic [2:0]       irq_en_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_bit8_o,
  output logic             rx_full_o,
  output logic             rx_ovf_o,
  output logic             start_err_o,
  output logic             irq_o
);
  logic       line, fall, done, bit8, start_fail;
  logic [7:0] word;

  uart_mp_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .line_o (line),
    .fall_o (fall)
  );

  uart_mp_rx_frame #(.CNT_W(CNT_W)) i_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .line_i       (line),
    .fall_i       (fall),
    .bit_period_i (bit_period_i),
    .nine_bit_i   (nine_bit_i),
    .mp_filter_i  (mp_filter_i),
    .done_o       (done),
    .data_o       (word),
    .bit8_o       (bit8),
    .start_fail_o (start_fail)
  );

  uart_mp_rx_status i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .done_i       (done),
    .data_i       (word),
    .bit8_i       (bit8),
    .start_fail_i (start_fail),
    .rd_data_i    (rd_data_i),
    .rd_stat_i    (rd_stat_i),
    .irq_en_i     (irq_en_i),
    .data_o       (rx_data_o),
    .bit8_o       (rx_bit8_o),
    .full_o       (rx_full_o),
    .ovf_o        (rx_ovf_o),
    .serr_o       (start_err_o),
    .irq_o        (irq_o)
  );

  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == 3'b000) |-> !irq_o);
endmodule

// File: tb/test_uart_mp_rx.sv
module test_uart_mp_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_P      = 16;

  typedef struct {
    logic [7:0] data;
    logic       b8, full, ovf, serr;
    string      tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        rxd_i = 1'b1;
  logic [15:0] bit_period_i = 16'(BIT_P);
  logic        nine_bit_i = 1'b0;
  logic        mp_filter_i = 1'b0;
  logic        rd_data_i = 1'b0;
  logic        rd_stat_i = 1'b0;
  logic [2:0]  irq_en_i = 3'b000;
  logic [7:0]  rx_data_o;
  logic        rx_bit8_o, rx_full_o, rx_ovf_o, start_err_o, irq_o;

  int   n_vec = 0;
  int   n_err = 0;
  bit   done_flag = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_mp_rx i_uart_mp_rx (
    .clk_i, .rst_ni, .en_i, .rxd_i, .bit_period_i, .nine_bit_i, .mp_filter_i,
    .rd_data_i, .rd_stat_i, .irq_en_i, .rx_data_o, .rx_bit8_o, .rx_full_o,
    .rx_ovf_o, .start_err_o, .irq_o
  );

  task automatic chk(string tag, string what, logic [8:0] act, logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares at the next falling clock edge
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      @(negedge clk_i);
      begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "data", {1'b0, rx_data_o}, {1'b0, e.data});
        chk(e.tag, "bit8", {8'b0, rx_bit8_o}, {8'b0, e.b8});
        chk(e.tag, "full", {8'b0, rx_full_o}, {8'b0, e.full});
        chk(e.tag, "ovf",  {8'b0, rx_ovf_o},  {8'b0, e.ovf});
        chk(e.tag, "serr", {8'b0, start_err_o}, {8'b0, e.serr});
      end
    end
  end

  task automatic expect_st(logic [7:0] d, logic b8, logic f, logic o, logic s, string tag);
    exp_t e;
    e.data = d; e.b8 = b8; e.full = f; e.ovf = o; e.serr = s; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    @(negedge clk_i);
  endtask

  task automatic send(logic [8:0] w, int nbits, logic stop_lvl);
    @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (BIT_P) @(negedge clk_i);
    for (int i = 0; i < nbits; i++) begin
      rxd_i = w[i];
      repeat (BIT_P) @(negedge clk_i);
    end
    rxd_i = stop_lvl;
    repeat (BIT_P) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (BIT_P) @(negedge clk_i);
  endtask

  task automatic glitch();
    @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (2 * BIT_P) @(negedge clk_i);
  endtask

  task automatic pulse_rd_data();
    @(negedge clk_i); rd_data_i = 1'b1;
    @(negedge clk_i); rd_data_i = 1'b0;
  endtask

  task automatic pulse_rd_stat();
    @(negedge clk_i); rd_stat_i = 1'b1;
    @(negedge clk_i); rd_stat_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_vec++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", "irq", {8'b0, irq_o}, 9'h0);
    expect_st(8'h00, 0, 0, 0, 0, "R10");
    rst_ni = 1'b1; en_i = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 R3: 8-bit, filter off, LSB first
    send(9'h0A5, 8, 1'b1);
    expect_st(8'hA5, 1, 1, 0, 0, "R3");
    irq_en_i = 3'b100;
    @(negedge clk_i);
    chk("R9", "irq_full", {8'b0, irq_o}, 9'h1);
    irq_en_i = 3'b011;
    @(negedge clk_i);
    chk("R9", "irq_masked", {8'b0, irq_o}, 9'h0);
    irq_en_i = 3'b000;
    pulse_rd_data();
    expect_st(8'hA5, 1, 0, 0, 0, "R6");

    // R3: stop bit low still stored
    send(9'h03C, 8, 1'b0);
    expect_st(8'h3C, 0, 1, 0, 0, "R3");
    pulse_rd_data();

    // R4: filter drops stop=0
    mp_filter_i = 1'b1;
    send(9'h05A, 8, 1'b0);
    expect_st(8'h3C, 0, 0, 0, 0, "R4");
    send(9'h081, 8, 1'b1);
    expect_st(8'h81, 1, 1, 0, 0, "R4");
    mp_filter_i = 1'b0;

    // R7: overrun keeps data, overwrites flag bit
    send(9'h077, 8, 1'b0);
    expect_st(8'h81, 0, 1, 1, 0, "R7");
    irq_en_i = 3'b010;
    @(negedge clk_i);
    chk("R9", "irq_ovf", {8'b0, irq_o}, 9'h1);
    irq_en_i = 3'b000;

    // R2: start glitch
    glitch();
    expect_st(8'h81, 0, 1, 1, 1, "R2");
    irq_en_i = 3'b001;
    @(negedge clk_i);
    chk("R9", "irq_serr", {8'b0, irq_o}, 9'h1);
    irq_en_i = 3'b000;

    // R8 R6: disable clears error flags, keeps full
    @(negedge clk_i); en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    expect_st(8'h81, 0, 1, 0, 0, "R8");
    en_i = 1'b1;
    repeat (2) @(negedge clk_i);

    // R8: status read clears both
    glitch();
    send(9'h011, 8, 1'b1);
    expect_st(8'h81, 1, 1, 1, 1, "R8");
    pulse_rd_stat();
    expect_st(8'h81, 1, 1, 0, 0, "R8");
    pulse_rd_data();

    // R2: reception continues after a start error
    glitch();
    send(9'h0C6, 8, 1'b1);
    expect_st(8'hC6, 1, 1, 0, 1, "R2");
    pulse_rd_stat();
    pulse_rd_data();

    // R5: 9-bit mode
    nine_bit_i = 1'b1;
    send(9'h1C3, 9, 1'b1);
    expect_st(8'hC3, 1, 1, 0, 0, "R5");
    pulse_rd_data();
    send(9'h0A5, 9, 1'b0);
    expect_st(8'hA5, 0, 1, 0, 0, "R5");
    pulse_rd_data();
    mp_filter_i = 1'b1;
    send(9'h042, 9, 1'b1);
    expect_st(8'hA5, 0, 0, 0, 0, "R5");
    send(9'h166, 9, 1'b0);
    expect_st(8'h66, 1, 1, 0, 0, "R5");

    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule